// File: doc/BRIEF.md
# UART FIFO Interrupt Pin Controller

This block keeps track of how full a serial port's transmit and receive paths are and drives a single interrupt pin from that state. Each direction stores bytes in a 64-entry FIFO with a level counter. When FIFO operation is switched off, each direction holds at most one byte, like a plain holding register. The CPU writes bytes for transmission and reads received bytes. The serializer removes transmit bytes and the deserializer adds receive bytes. All four actions arrive as single-cycle strobes.

The transmit path requests service when it can accept more data. With FIFOs off, that means its holding register is empty. With FIFOs on, that means its level is below the transmit trigger. The receive path requests service when data is waiting. With FIFOs off, that means one byte is held. With FIFOs on, that means its level has reached the receive trigger. Each request is gated by its own enable input, and the two gated requests are ORed into a registered pending flag. A bus-style strap input sets whether the pin is driven active-high or active-low.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset both levels read 0, FIFO operation is off, and the pin sits at its inactive level (0 when `bus_mode`=1, 1 when `bus_mode`=0).
- R2: With FIFOs off, the transmit request is active exactly when the transmit level is 0. A write while one byte is held is dropped, and the level stays 1.
- R3: With FIFOs off, the receive request is active exactly when one byte is held. A received byte arriving while one is held is dropped.
- R4: With FIFOs on, the transmit request is active when the transmit level is strictly below the transmit trigger. A level equal to the trigger is not active.
- R5: With FIFOs on, the receive request is active when the receive level is greater than or equal to the receive trigger.
- R6: A control write takes bit 0 of `fcr_wdata` as the FIFO enable. A write that changes this bit clears both levels in the same edge. A write that keeps the bit unchanged clears nothing. Bit 3 and all other bits have no effect.
- R7: When `bus_mode`=1 the pin reads 1 when an interrupt is pending. When `bus_mode`=0 the pin reads 0 when an interrupt is pending.
- R8: The transmit request contributes only while `ier_tx_en`=1, and the receive request contributes only while `ier_rx_en`=1.
- R9: With FIFOs on, a write to a path holding 64 bytes is dropped. A read or serializer take from an empty path returns 0 and leaves the level at 0.
- R10: A trigger value of 0 acts as 1, and a trigger value above 64 acts as 64.
- R11: The pending flag is registered. The pin reflects levels, triggers and enables as they stood one clock earlier, so a level change shows on the pin one edge after the level output changes.
- R12: Each path returns bytes in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 1 | Pin polarity: 1 selects active-high, 0 selects active-low |
| ier_tx_en | input | 1 | Transmit interrupt enable |
| ier_rx_en | input | 1 | Receive interrupt enable |
| fcr_wr | input | 1 | Control register write strobe |
| fcr_wdata | input | 8 | Control data; bit 0 is the FIFO enable |
| tx_trig | input | 8 | Transmit trigger level (1..64) |
| rx_trig | input | 8 | Receive trigger level (1..64) |
| tx_push | input | 1 | CPU writes a transmit byte |
| tx_wdata | input | 8 | Transmit byte from the CPU |
| tx_pop | input | 1 | Serializer takes a transmit byte |
| tx_rdata | output | 8 | Oldest transmit byte, 0 when empty |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | CPU reads a received byte |
| rx_rdata | output | 8 | Oldest received byte, 0 when empty |
| tx_level | output | 7 | Transmit level counter |
| rx_level | output | 7 | Receive level counter |
| irq_pin | output | 1 | Interrupt pin |

## Verification
The bench targets the trigger boundaries. At a level equal to the trigger, the receive request must be active and the transmit request must not be. An off-by-one compare would move the pin one byte early or one byte late. It also covers clamped trigger values of 0 and of more than 64, a second byte offered to a single holding register, a 65th write, and reads from an empty path. A design that mishandled these would overflow its counter, wrap the level, or return stale bytes. Control writes that touch only bit 3, or that repeat the current enable, must leave the levels intact, while a real enable change must empty both paths. Under the active-low strap the pin must invert, and after every level change the pin is expected to lag the level output by exactly one edge.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int TW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_mode,
  input  logic          ier_tx_en,
  input  logic          ier_rx_en,
  input  logic          fcr_wr,
  input  logic [7:0]    fcr_wdata,
  input  logic [TW-1:0] tx_trig,
  input  logic [TW-1:0] rx_trig,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_rdata,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_wdata,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_rdata,
  output logic [$clog2(DEPTH):0] tx_level,
  output logic [$clog2(DEPTH):0] rx_level,
  output logic          irq_pin
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          fifo_en;
  logic          pend_q;
  logic [CW-1:0] tx_cnt, rx_cnt, cap;
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic          mode_flip, tx_in, tx_out, rx_in, rx_out;
  logic [CW-1:0] tx_thr, rx_thr;
  logic          tx_req, rx_req;
  logic          unused_fcr;

  function automatic logic [CW-1:0] clamp_trig(input logic [TW-1:0] t);
    if (t == '0) return CW'(1);
    if (32'(t) > DEPTH) return CW'(DEPTH);
    return CW'(t);
  endfunction

  assign unused_fcr = ^fcr_wdata[7:1];
  assign mode_flip  = fcr_wr && (fcr_wdata[0] != fifo_en);
  assign cap        = fifo_en ? CW'(DEPTH) : CW'(1);

  assign tx_in  = tx_push && (tx_cnt < cap);
  assign tx_out = tx_pop  && (tx_cnt != '0);
  assign rx_in  = rx_push && (rx_cnt < cap);
  assign rx_out = rx_pop  && (rx_cnt != '0);

  assign tx_rdata = (tx_cnt == '0) ? '0 : tx_mem[tx_rp];
  assign rx_rdata = (rx_cnt == '0) ? '0 : rx_mem[rx_rp];
  assign tx_level = tx_cnt;
  assign rx_level = rx_cnt;

  assign tx_thr = clamp_trig(tx_trig);
  assign rx_thr = clamp_trig(rx_trig);
  assign tx_req = fifo_en ? (tx_cnt < tx_thr)  : (tx_cnt == '0);
  assign rx_req = fifo_en ? (rx_cnt >= rx_thr) : (rx_cnt != '0);

  assign irq_pin = bus_mode ? pend_q : ~pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en <= 1'b0;
      pend_q  <= 1'b0;
      tx_cnt  <= '0;
      rx_cnt  <= '0;
      tx_wp   <= '0;
      tx_rp   <= '0;
      rx_wp   <= '0;
      rx_rp   <= '0;
    end else begin
      pend_q <= (tx_req && ier_tx_en) || (rx_req && ier_rx_en);
      if (fcr_wr) fifo_en <= fcr_wdata[0];
      if (mode_flip) begin
        tx_cnt <= '0;
        rx_cnt <= '0;
        tx_wp  <= '0;
        tx_rp  <= '0;
        rx_wp  <= '0;
        rx_rp  <= '0;
      end else begin
        tx_cnt <= tx_cnt + CW'(tx_in) - CW'(tx_out);
        rx_cnt <= rx_cnt + CW'(rx_in) - CW'(rx_out);
        if (tx_in)  tx_wp <= tx_wp + 1'b1;
        if (tx_out) tx_rp <= tx_rp + 1'b1;
        if (rx_in)  rx_wp <= rx_wp + 1'b1;
        if (rx_out) rx_rp <= rx_rp + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tx_in && !mode_flip) tx_mem[tx_wp] <= tx_wdata;
    if (rx_in && !mode_flip) rx_mem[rx_wp] <= rx_wdata;
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_cnt) <= DEPTH) && (32'(rx_cnt) <= DEPTH));

  assert_single_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (tx_cnt <= 1) && (rx_cnt <= 1));

  assert_mode_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flip |=> (tx_level == '0) && (rx_level == '0));

  assert_empty_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> (rx_rdata == '0));

  assert_gated_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ier_tx_en && !ier_rx_en) |=> (irq_pin == !bus_mode));

  assert_unit_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_flip |=> (tx_cnt == $past(tx_cnt) || tx_cnt == $past(tx_cnt) + 1'b1 ||
                    tx_cnt == $past(tx_cnt) - 1'b1));
endmodule

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/1ps
module sim_uart_irq_ctrl;
  localparam int DEPTH = 64;

  logic       clk = 1'b0, rst_n = 1'b0, bus_mode = 1'b1;
  logic       ier_tx_en = 1'b0, ier_rx_en = 1'b0, fcr_wr = 1'b0;
  logic [7:0] fcr_wdata = '0, tx_trig = 8'd1, rx_trig = 8'd1;
  logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
  logic [6:0] tx_level, rx_level;
  logic       irq_pin;

  uart_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .bus_mode(bus_mode),
    .ier_tx_en(ier_tx_en), .ier_rx_en(ier_rx_en), .fcr_wr(fcr_wr),
    .fcr_wdata(fcr_wdata), .tx_trig(tx_trig), .rx_trig(rx_trig),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .tx_level(tx_level), .rx_level(rx_level), .irq_pin(irq_pin));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int mtx = 0, mrx = 0;
  bit fon = 0, done = 0;
  byte unsigned qtx[$], qrx[$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int thr(input logic [7:0] t);
    if (t == 0) return 1;
    if (t > DEPTH) return DEPTH;
    return int'(t);
  endfunction

  function automatic bit exp_pin();
    bit txa, rxa, p;
    txa = fon ? (mtx < thr(tx_trig)) : (mtx == 0);
    rxa = fon ? (mrx >= thr(rx_trig)) : (mrx != 0);
    p = (txa && ier_tx_en) || (rxa && ier_rx_en);
    return bus_mode ? p : !p;
  endfunction

  function automatic int cap();
    return fon ? DEPTH : 1;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check_all(string tag);
    tick();
    chk({tag, " pin"}, irq_pin, exp_pin());
    chk({tag, " txlvl"}, tx_level, mtx);
    chk({tag, " rxlvl"}, rx_level, mrx);
  endtask

  task automatic cpu_write(byte unsigned b);
    tx_push = 1; tx_wdata = b; tick(); tx_push = 0;
    if (mtx < cap()) begin qtx.push_back(b); mtx++; end
  endtask

  task automatic ser_take();
    tx_pop = 1; tick(); tx_pop = 0;
    if (mtx > 0) mtx--;
  endtask

  task automatic rx_in(byte unsigned b);
    rx_push = 1; rx_wdata = b; tick(); rx_push = 0;
    if (mrx < cap()) begin qrx.push_back(b); mrx++; end
  endtask

  task automatic cpu_read();
    rx_pop = 1; tick(); rx_pop = 0;
    if (mrx > 0) mrx--;
  endtask

  task automatic fcr(logic [7:0] v);
    fcr_wr = 1; fcr_wdata = v; tick(); fcr_wr = 0;
    if (v[0] != fon) begin
      fon = v[0]; mtx = 0; mrx = 0; qtx.delete(); qrx.delete();
    end
  endtask

  // scoreboard monitor: compares output bytes against queued expectations
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (tx_pop) begin
        if (qtx.size() > 0) chk("R12 tx order", tx_rdata, qtx.pop_front());
        else chk("R9 tx empty take", tx_rdata, 0);
      end
      if (rx_pop) begin
        if (qrx.size() > 0) chk("R12 rx order", rx_rdata, qrx.pop_front());
        else chk("R9 rx empty read", rx_rdata, 0);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit prev;
    tick(); tick();
    rst_n = 1; #1;
    chk("R1 reset pin", irq_pin, 0);
    chk("R1 reset txlvl", tx_level, 0);
    chk("R1 reset rxlvl", rx_level, 0);
    check_all("R1");

    ier_tx_en = 1;
    check_all("R2 empty holding");
    prev = exp_pin();
    cpu_write(8'hA5);
    chk("R11 pin lags level", irq_pin, prev);
    chk("R11 level moved", tx_level, 1);
    check_all("R2 one held");
    cpu_write(8'h5A);
    check_all("R2 second dropped");
    ser_take();
    check_all("R2 drained");

    ier_tx_en = 0; ier_rx_en = 1;
    check_all("R3 no data");
    rx_in(8'h11);
    check_all("R3 byte held");
    rx_in(8'h22);
    check_all("R3 second dropped");
    ier_rx_en = 0;
    check_all("R8 rx gated");
    ier_rx_en = 1;
    fcr(8'h08);
    check_all("R6 bit3 no effect");
    cpu_read();
    check_all("R3 read out");

    rx_in(8'h33);
    fcr(8'h09);
    check_all("R6 enable clears");
    rx_trig = 8'd4;
    for (int i = 0; i < 3; i++) rx_in(8'(i + 1));
    check_all("R5 below trigger");
    rx_in(8'h44);
    check_all("R5 at trigger");
    cpu_read();
    check_all("R5 back below");

    ier_rx_en = 0; ier_tx_en = 1; tx_trig = 8'd3;
    check_all("R4 empty");
    cpu_write(8'h01); cpu_write(8'h02);
    check_all("R4 below trigger");
    cpu_write(8'h03);
    check_all("R4 at trigger");
    for (int i = 3; i < DEPTH + 1; i++) cpu_write(8'(i + 16));
    check_all("R9 full drop");
    for (int i = 0; i < DEPTH + 1; i++) ser_take();
    check_all("R9 tx drained");
    for (int i = 0; i < 8; i++) cpu_read();
    check_all("R9 rx empty");

    tx_trig = 8'd0;
    check_all("R10 zero trig empty");
    cpu_write(8'h7E);
    check_all("R10 zero trig acts as one");
    ser_take();
    ier_tx_en = 0; ier_rx_en = 1; rx_trig = 8'd200;
    for (int i = 0; i < DEPTH - 1; i++) rx_in(8'(i * 3));
    check_all("R10 large trig below");
    rx_in(8'hEE);
    check_all("R10 large trig at 64");

    bus_mode = 0;
    check_all("R7 active low pending");
    fcr(8'h01);
    check_all("R6 same value keeps");
    cpu_read();
    check_all("R7 active low idle");
    bus_mode = 1;
    check_all("R7 active high idle");
    for (int i = 0; i < 4; i++) cpu_read();
    fcr(8'h00);
    check_all("R6 disable clears");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule